// File: doc/BRIEF.md
# Misaligned Access Splitter

This block sits between a load/store unit and a protection checker. It takes one memory access at a time, given as a start address and a size, and decides how that access is presented to the checker. An access that stays inside one naturally aligned block is always passed through whole. An access that crosses such a boundary is handled according to a mode: it is trapped with a misaligned-address exception, passed through whole so that the checker judges it as one unit, or split at the aligned boundary into two parts that are checked and committed one after the other, lower part first or upper part first.

Each part that the checker accepts commits at once, so with the lower part first a store can leave its lower half written when the upper half then faults. The first fault met in issue order ends the access, and the part that would follow is never issued. When the access ends, the block gives one completion pulse carrying the exception code, the address that caused it and the number of parts that committed. The mode comes from an input sampled when the access is accepted, or from a fixed parameter.

Top module: `msplit_top`

## Requirements
- R1: After reset, `req_ready` is 1, `chk_valid` is 0 and `done_valid` is 0.
- R2: An access whose address is a multiple of its byte length (length = 2^`req_size`) is issued once with its own address and full length in every mode; if the checker accepts it, completion shows exception code 0 (none) and 1 committed part.
- R3: In mode 0 (trap) a misaligned access issues no check and completes with exception code 1 (misaligned), the request address as fault address and 0 committed parts.
- R4: In mode 1 (whole) a misaligned access is issued once with its own address and full length; if the checker rejects it, completion shows exception code 2 (access fault), the request address and 0 committed parts.
- R5: In modes 2 and 3 a misaligned access is split at the next aligned boundary B: the lower part runs from the request address to B, the upper part from B with the remaining bytes, so the two committed parts together cover the full length.
- R6: In mode 2 (split, lower first) the lower part is issued before the upper part; if only the upper part faults, completion shows code 2, fault address B and 1 committed part.
- R7: In mode 3 (split, upper first) the upper part is issued first; if it faults, the lower part is not issued and completion shows code 2, fault address B and 0 committed parts.
- R8: A fault on the first issued part ends the access: no second part is issued, and the fault address is the start of the part that faulted.
- R9: The mode is sampled in the cycle the access is accepted; changes of `req_mode` while the access is in progress have no effect on its issue order or result.
- R10: `req_ready` is 0 from acceptance until the cycle after the completion pulse; `done_valid` is high for exactly one cycle per access and `chk_valid` is never high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New access offered |
| req_ready | output | 1 | Block is idle and accepts an access |
| req_addr | input | ADDR_W | Byte start address of the access |
| req_size | input | SIZE_W | Log2 of the access length in bytes |
| req_mode | input | 2 | 0 trap, 1 whole, 2 split lower first, 3 split upper first |
| chk_valid | output | 1 | A part is presented to the protection checker |
| chk_addr | output | ADDR_W | Start address of the presented part |
| chk_len | output | LEN_W | Byte length of the presented part |
| chk_fault | input | 1 | Checker rejects the presented part (same cycle) |
| commit_valid | output | 1 | The presented part passed and commits |
| done_valid | output | 1 | One-cycle completion pulse |
| done_exc | output | 2 | 0 none, 1 misaligned, 2 access fault |
| done_addr | output | ADDR_W | Address associated with the exception |
| done_commits | output | 2 | Number of parts committed |

## Verification
The bench plays the protection checker with a map of 16-byte entries in which one entry is forbidden and any range crossing an entry boundary is refused. The same 8-byte access that is 4-byte but not 8-byte aligned is run in all four modes against the forbidden entry, which tells trap, whole-unit fault, lower-first partial commit and upper-first early abort apart by exception code, committed count and the first and last issued address. The same access in a permitted area separates whole mode (refused for crossing) from the split modes (both parts commit), and 2- and 4-byte cases with a one- or two-byte offset show where the split boundary falls and which part faults first. Aligned accesses in every mode, a mode change during an access and the ready and completion handshake cover the remaining behaviour.

// File: rtl/msplit_pkg.sv
package msplit_pkg;

   typedef enum logic [1:0] {
      MODE_TRAP     = 2'd0,
      MODE_WHOLE    = 2'd1,
      MODE_SPLIT_LO = 2'd2,
      MODE_SPLIT_HI = 2'd3
   } msplit_mode_e;

   typedef enum logic [1:0] {
      EXC_NONE     = 2'd0,
      EXC_MISALIGN = 2'd1,
      EXC_ACCESS   = 2'd2
   } msplit_exc_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HALF0 = 2'd1,
      ST_HALF1 = 2'd2,
      ST_DONE  = 2'd3
   } msplit_state_e;

endpackage

// File: rtl/msplit_decode.sv
module msplit_decode #(
   parameter int ADDR_W        = 32,
   parameter int MAX_SIZE_LOG2 = 3,
   localparam int SIZE_W       = $clog2(MAX_SIZE_LOG2 + 1),
   localparam int LEN_W        = MAX_SIZE_LOG2 + 1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SIZE_W-1:0] size,
   output logic              misaligned,
   output logic [LEN_W-1:0]  full_len,
   output logic [LEN_W-1:0]  lo_len,
   output logic [ADDR_W-1:0] hi_addr,
   output logic [LEN_W-1:0]  hi_len
);

   logic [LEN_W-1:0] nbytes;
   logic [LEN_W-1:0] offset;

   always_comb begin
      nbytes     = LEN_W'(1) << size;
      offset     = addr[LEN_W-1:0] & (nbytes - LEN_W'(1));
      misaligned = (offset != '0);
      full_len   = nbytes;
      lo_len     = nbytes - offset;
      hi_len     = offset;
      hi_addr    = addr + ADDR_W'(lo_len);
   end

endmodule

// File: rtl/msplit_issue.sv
module msplit_issue
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 4
) (
   input  msplit_state_e     st,
   input  logic              do_split,
   input  logic              hi_first,
   input  logic [ADDR_W-1:0] orig_addr,
   input  logic [LEN_W-1:0]  full_len,
   input  logic [LEN_W-1:0]  lo_len,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic [LEN_W-1:0]  hi_len,
   output logic              chk_valid,
   output logic [ADDR_W-1:0] chk_addr,
   output logic [LEN_W-1:0]  chk_len
);

   logic pick_hi;

   always_comb begin
      chk_valid = (st == ST_HALF0) || (st == ST_HALF1);
      // first part is the upper one only for upper-first splits
      pick_hi   = do_split && ((st == ST_HALF0) ? hi_first : !hi_first);
      if (!do_split) begin
         chk_addr = orig_addr;
         chk_len  = full_len;
      end else if (pick_hi) begin
         chk_addr = hi_addr;
         chk_len  = hi_len;
      end else begin
         chk_addr = orig_addr;
         chk_len  = lo_len;
      end
   end

endmodule

// File: rtl/msplit_seq.sv
module msplit_seq
   import msplit_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  msplit_mode_e      mode_in,
   input  logic              dec_mis,
   input  logic [LEN_W-1:0]  dec_full_len,
   input  logic [LEN_W-1:0]  dec_lo_len,
   input  logic [ADDR_W-1:0] dec_hi_addr,
   input  logic [LEN_W-1:0]  dec_hi_len,
   input  logic [ADDR_W-1:0] chk_addr,
   input  logic              chk_fault,
   output msplit_state_e     st,
   output logic              do_split,
   output logic              hi_first,
   output logic [ADDR_W-1:0] orig_addr,
   output logic [LEN_W-1:0]  full_len,
   output logic [LEN_W-1:0]  lo_len,
   output logic [ADDR_W-1:0] hi_addr,
   output logic [LEN_W-1:0]  hi_len,
   output logic              req_ready,
   output logic              done_valid,
   output logic [1:0]        done_exc,
   output logic [ADDR_W-1:0] done_addr,
   output logic [1:0]        done_commits
);

   msplit_mode_e mode_q;
   logic         mis_q;
   msplit_exc_e  exc_q;
   logic [ADDR_W-1:0] fault_q;
   logic [1:0]   commits_q;

   always_comb begin
      do_split = mis_q && ((mode_q == MODE_SPLIT_LO) || (mode_q == MODE_SPLIT_HI));
      hi_first = (mode_q == MODE_SPLIT_HI);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         mode_q    <= MODE_TRAP;
         mis_q     <= 1'b0;
         orig_addr <= '0;
         full_len  <= '0;
         lo_len    <= '0;
         hi_addr   <= '0;
         hi_len    <= '0;
         exc_q     <= EXC_NONE;
         fault_q   <= '0;
         commits_q <= '0;
      end else begin
         unique case (st)
            ST_IDLE: if (req_valid) begin
               mode_q    <= mode_in;
               mis_q     <= dec_mis;
               orig_addr <= req_addr;
               full_len  <= dec_full_len;
               lo_len    <= dec_lo_len;
               hi_addr   <= dec_hi_addr;
               hi_len    <= dec_hi_len;
               commits_q <= '0;
               fault_q   <= req_addr;
               if (dec_mis && (mode_in == MODE_TRAP)) begin
                  exc_q <= EXC_MISALIGN;
                  st    <= ST_DONE;
               end else begin
                  exc_q <= EXC_NONE;
                  st    <= ST_HALF0;
               end
            end
            ST_HALF0: begin
               if (chk_fault) begin
                  exc_q   <= EXC_ACCESS;
                  fault_q <= chk_addr;
                  st      <= ST_DONE;
               end else begin
                  commits_q <= 2'd1;
                  st        <= do_split ? ST_HALF1 : ST_DONE;
               end
            end
            ST_HALF1: begin
               if (chk_fault) begin
                  exc_q   <= EXC_ACCESS;
                  fault_q <= chk_addr;
               end else begin
                  commits_q <= 2'd2;
               end
               st <= ST_DONE;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      req_ready    = (st == ST_IDLE);
      done_valid   = (st == ST_DONE);
      done_exc     = exc_q;
      done_addr    = fault_q;
      done_commits = commits_q;
   end

   // a misaligned access in trap mode never reaches the checker
   p_trap_no_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HALF0) |-> !(mode_q == MODE_TRAP && mis_q));

   // the second part only follows a first part that passed
   p_second_after_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HALF1) |-> ($past(st) == ST_HALF0 && !$past(chk_fault)));

   // mode latched at acceptance stays put for the whole access
   p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(mode_q));

   // completion lasts one cycle and returns to idle
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE) |=> (st == ST_IDLE));

   // a clean finish commits every part that was planned
   p_full_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DONE && exc_q == EXC_NONE) |-> (commits_q == (do_split ? 2'd2 : 2'd1)));

endmodule

// File: rtl/msplit_top.sv
module msplit_top
   import msplit_pkg::*;
#(
   parameter int ADDR_W        = 32,
   parameter int MAX_SIZE_LOG2 = 3,
   parameter bit DYN_MODE      = 1'b1,
   parameter int STATIC_MODE   = 2,
   localparam int SIZE_W       = $clog2(MAX_SIZE_LOG2 + 1),
   localparam int LEN_W        = MAX_SIZE_LOG2 + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [1:0]        req_mode,
   output logic              chk_valid,
   output logic [ADDR_W-1:0] chk_addr,
   output logic [LEN_W-1:0]  chk_len,
   input  logic              chk_fault,
   output logic              commit_valid,
   output logic              done_valid,
   output logic [1:0]        done_exc,
   output logic [ADDR_W-1:0] done_addr,
   output logic [1:0]        done_commits
);

   if (MAX_SIZE_LOG2 < 1 || MAX_SIZE_LOG2 > 4) begin : g_bad_size
      $error("MAX_SIZE_LOG2 must lie in 1..4");
   end
   if (ADDR_W < LEN_W + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the largest access");
   end
   if (STATIC_MODE < 0 || STATIC_MODE > 3) begin : g_bad_mode
      $error("STATIC_MODE must lie in 0..3");
   end

   msplit_mode_e mode_in;

   if (DYN_MODE) begin : g_dyn_mode
      assign mode_in = msplit_mode_e'(req_mode);
   end else begin : g_fixed_mode
      assign mode_in = msplit_mode_e'(STATIC_MODE[1:0]);
   end

   logic              dec_mis;
   logic [LEN_W-1:0]  dec_full_len, dec_lo_len, dec_hi_len;
   logic [ADDR_W-1:0] dec_hi_addr;

   msplit_decode #(.ADDR_W(ADDR_W), .MAX_SIZE_LOG2(MAX_SIZE_LOG2)) u_decode (
      .addr       (req_addr),
      .size       (req_size),
      .misaligned (dec_mis),
      .full_len   (dec_full_len),
      .lo_len     (dec_lo_len),
      .hi_addr    (dec_hi_addr),
      .hi_len     (dec_hi_len)
   );

   msplit_state_e     st;
   logic              do_split, hi_first;
   logic [ADDR_W-1:0] orig_addr, hi_addr;
   logic [LEN_W-1:0]  full_len, lo_len, hi_len;

   msplit_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_addr     (req_addr),
      .mode_in      (mode_in),
      .dec_mis      (dec_mis),
      .dec_full_len (dec_full_len),
      .dec_lo_len   (dec_lo_len),
      .dec_hi_addr  (dec_hi_addr),
      .dec_hi_len   (dec_hi_len),
      .chk_addr     (chk_addr),
      .chk_fault    (chk_fault),
      .st           (st),
      .do_split     (do_split),
      .hi_first     (hi_first),
      .orig_addr    (orig_addr),
      .full_len     (full_len),
      .lo_len       (lo_len),
      .hi_addr      (hi_addr),
      .hi_len       (hi_len),
      .req_ready    (req_ready),
      .done_valid   (done_valid),
      .done_exc     (done_exc),
      .done_addr    (done_addr),
      .done_commits (done_commits)
   );

   msplit_issue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_issue (
      .st        (st),
      .do_split  (do_split),
      .hi_first  (hi_first),
      .orig_addr (orig_addr),
      .full_len  (full_len),
      .lo_len    (lo_len),
      .hi_addr   (hi_addr),
      .hi_len    (hi_len),
      .chk_valid (chk_valid),
      .chk_addr  (chk_addr),
      .chk_len   (chk_len)
   );

   assign commit_valid = chk_valid && !chk_fault;

   // no part reaches the checker while a new access could be taken
   p_busy_blocks_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |-> !req_ready);

   // every part that is presented stays inside one aligned block
   p_part_inside_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && do_split) |->
         ((chk_addr[LEN_W-1:0] & (full_len - LEN_W'(1))) + chk_len <= full_len));

   p_legal_size_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> (int'(req_size) <= MAX_SIZE_LOG2));

endmodule

// File: tb/sim_msplit_top.sv
module sim_msplit_top;

   localparam int AW = 32;
   localparam int NV = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [1:0]  req_mode = '0;
   logic        chk_valid;
   logic [31:0] chk_addr;
   logic [3:0]  chk_len;
   logic        chk_fault;
   logic        commit_valid;
   logic        done_valid;
   logic [1:0]  done_exc;
   logic [31:0] done_addr;
   logic [1:0]  done_commits;

   always #5 clk = ~clk;

   msplit_top u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_mode(req_mode),
      .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_len(chk_len),
      .chk_fault(chk_fault), .commit_valid(commit_valid), .done_valid(done_valid),
      .done_exc(done_exc), .done_addr(done_addr), .done_commits(done_commits)
   );

   // checker model: 16-byte entries, entry 0x10..0x1F forbidden,
   // any range crossing an entry boundary refused
   function automatic logic prot_fault(input logic [31:0] a, input logic [3:0] len);
      logic [31:0] e;
      e = a + 32'(len) - 32'd1;
      return (a[31:4] != e[31:4]) || (a[31:4] == 28'h1) || (e[31:4] == 28'h1);
   endfunction

   assign chk_fault = chk_valid && prot_fault(chk_addr, chk_len);

   typedef struct packed {
      logic [1:0]  mode;
      logic [31:0] addr;
      logic [1:0]  size;
      logic [1:0]  exc;
      logic [31:0] faddr;
      logic [1:0]  commits;
      logic [1:0]  issues;
      logic [31:0] first;
      logic [31:0] last;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{2'd2, 32'h0C, 2'd3, 2'd2, 32'h10, 2'd1, 2'd2, 32'h0C, 32'h10}, // R6
      '{2'd3, 32'h0C, 2'd3, 2'd2, 32'h10, 2'd0, 2'd1, 32'h10, 32'h10}, // R7
      '{2'd1, 32'h0C, 2'd3, 2'd2, 32'h0C, 2'd0, 2'd1, 32'h0C, 32'h0C}, // R4
      '{2'd0, 32'h0C, 2'd3, 2'd1, 32'h0C, 2'd0, 2'd0, 32'h00, 32'h00}, // R3
      '{2'd2, 32'h2C, 2'd3, 2'd0, 32'h00, 2'd2, 2'd2, 32'h2C, 32'h30}, // R5
      '{2'd3, 32'h2C, 2'd3, 2'd0, 32'h00, 2'd2, 2'd2, 32'h30, 32'h2C}, // R5
      '{2'd1, 32'h2C, 2'd3, 2'd2, 32'h2C, 2'd0, 2'd1, 32'h2C, 32'h2C}, // R4
      '{2'd1, 32'h24, 2'd2, 2'd0, 32'h00, 2'd1, 2'd1, 32'h24, 32'h24}, // R2
      '{2'd0, 32'h28, 2'd3, 2'd0, 32'h00, 2'd1, 2'd1, 32'h28, 32'h28}, // R2
      '{2'd2, 32'h1E, 2'd2, 2'd2, 32'h1E, 2'd0, 2'd1, 32'h1E, 32'h1E}, // R8
      '{2'd3, 32'h1E, 2'd2, 2'd2, 32'h1E, 2'd1, 2'd2, 32'h20, 32'h1E}, // R7 second part faults
      '{2'd2, 32'h05, 2'd0, 2'd0, 32'h00, 2'd1, 2'd1, 32'h05, 32'h05}, // R2
      '{2'd2, 32'h03, 2'd1, 2'd0, 32'h00, 2'd2, 2'd2, 32'h03, 32'h04}, // R5
      '{2'd3, 32'h18, 2'd3, 2'd2, 32'h18, 2'd0, 2'd1, 32'h18, 32'h18}  // R8 aligned fault
   };

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   int          o_issues, o_commits, o_bytes, o_done_cycles;
   logic [31:0] o_first, o_last;
   logic [1:0]  o_exc, o_dcommits;
   logic [31:0] o_daddr;
   logic        o_ready_busy;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive one access; alt_mode != 4 replaces req_mode after acceptance
   task automatic run_access(input logic [1:0] mode, input logic [31:0] addr,
                             input logic [1:0] size, input int alt_mode);
      int guard;
      o_issues = 0; o_commits = 0; o_bytes = 0; o_done_cycles = 0;
      o_first = '0; o_last = '0; o_ready_busy = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = addr; req_size = size; req_mode = mode;
      @(negedge clk);
      req_valid = 1'b0;
      if (alt_mode != 4) req_mode = alt_mode[1:0];
      guard = 0;
      while (guard < 20) begin
         if (req_ready) o_ready_busy = 1'b1;
         if (chk_valid) begin
            if (o_issues == 0) o_first = chk_addr;
            o_last = chk_addr;
            o_issues++;
            if (commit_valid) begin
               o_commits++;
               o_bytes += int'(chk_len);
            end
         end
         if (done_valid) begin
            o_exc = done_exc; o_daddr = done_addr; o_dcommits = done_commits;
            break;
         end
         guard++;
         @(negedge clk);
      end
      @(negedge clk);
      if (done_valid) o_done_cycles = 2;
      else            o_done_cycles = 1;
   endtask

   initial begin
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 req_ready", 32'(req_ready), 32'd1);
      check("R1 chk_valid", 32'(chk_valid), 32'd0);
      check("R1 done_valid", 32'(done_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 ready after release", 32'(req_ready), 32'd1);

      // table of vectors covering R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         run_access(VECS[i].mode, VECS[i].addr, VECS[i].size, 4);
         check($sformatf("R2/R3/R4/R6/R7/R8 row %0d exc", i), 32'(o_exc), 32'(VECS[i].exc));
         check($sformatf("R2/R3/R4/R6/R7/R8 row %0d commits", i), 32'(o_dcommits), 32'(VECS[i].commits));
         check($sformatf("R8 row %0d issued parts", i), 32'(o_issues), 32'(VECS[i].issues));
         check($sformatf("R2/R5 row %0d committed pulses", i), 32'(o_commits), 32'(VECS[i].commits));
         if (VECS[i].issues != 0) begin
            check($sformatf("R5/R6/R7 row %0d first addr", i), o_first, VECS[i].first);
            check($sformatf("R5/R6/R7 row %0d last addr", i), o_last, VECS[i].last);
         end
         if (VECS[i].exc != 2'd0)
            check($sformatf("R3/R4/R6/R7/R8 row %0d fault addr", i), o_daddr, VECS[i].faddr);
         else
            check($sformatf("R5 row %0d bytes covered", i), 32'(o_bytes), 32'd1 << VECS[i].size);
         check($sformatf("R10 row %0d single done", i), 32'(o_done_cycles), 32'd1);
         check($sformatf("R10 row %0d busy ready", i), 32'(o_ready_busy), 32'd0);
      end

      // R9: start upper-first, switch input to lower-first mid access
      run_access(2'd3, 32'h0C, 2'd3, 2);
      check("R9 exc", 32'(o_exc), 32'd2);
      check("R9 commits", 32'(o_dcommits), 32'd0);
      check("R9 first addr", o_first, 32'h10);
      check("R9 issued parts", 32'(o_issues), 32'd1);

      // R9: start lower-first on a permitted area, switch to trap
      run_access(2'd2, 32'h2C, 2'd3, 0);
      check("R9 trap ignored exc", 32'(o_exc), 32'd0);
      check("R9 trap ignored commits", 32'(o_dcommits), 32'd2);

      // R10: idle again after completion, nothing presented
      check("R10 ready after done", 32'(req_ready), 32'd1);
      check("R10 no check when idle", 32'(chk_valid), 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule